// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Predecoder

This block sits between an instruction fetch buffer and the decoder. Bytes arrive one per handshake on a valid/ready input in big-endian instruction order. The byte that arrives first is always the most significant byte of the instruction. The block keeps the bytes in an internal byte queue and looks at the two bytes at the head of the queue. From that 16-bit prefix alone it decides the instruction format and the length in bytes. It does not know the length before it reads the prefix, so the format field must sit at a fixed place at the start of every instruction.

When the queue holds every byte of the head instruction, the block loads a registered output. The output carries the format, the length in bytes, the stream offset where the instruction starts, and the prefix itself. The bytes of that instruction are then removed from the queue. If the queue does not yet hold the whole instruction, the block waits and removes nothing. A synchronous flush empties the queue and the output stage, and it sets the stream offset back to zero.

The prefix fields are: a 6-bit major field in bits 15:10, a 3-bit selector in bits 9:7, and a 7-bit tail in bits 6:0. When the major field is zero and the selector is 10x, the instruction is a 64-bit prefixed one. When the major field is zero and the selector is 11x, the instruction is a variable-length block. For a block, the tail gives its total size in halfwords. The 48-bit and compressed formats are recognised by parameterised mask/match pairs. Any prefix that none of these rules matches is a plain 32-bit instruction.

Top module: `vlp_predecode`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first byte accepted for an instruction appears in `out_prefix[15:8]` and the second byte appears in `out_prefix[7:0]`.
- R3: A prefix with bits 15:10 = 0 and bits 9:7 = 100 or 101 is reported with `out_fmt` = 3 (64-bit) and `out_len` = 8.
- R4: A prefix with bits 15:10 = 0, bits 9:7 = 11x and tail N = bits 6:0 ≥ 2 is reported with `out_fmt` = 4 (block), `out_len` = 2·N bytes and `out_illegal` = 0.
- R5: A block prefix with N < 2 is reported with `out_fmt` = 4, `out_illegal` = 1 and `out_len` = 2, and it consumes exactly 2 bytes.
- R6: With the default parameters, a prefix with bits 15:10 = 1 is reported with `out_fmt` = 2 (48-bit) and `out_len` = 6.
- R7: With the default parameters, a prefix with bits 15:9 = 0 is reported with `out_fmt` = 0 (compressed) and `out_len` = 2.
- R8: Every other prefix is reported with `out_fmt` = 1 (plain) and `out_len` = 4.
- R9: An instruction is presented only after all of its bytes have been accepted. Until then, no byte is consumed and the following instructions keep their boundaries.
- R10: After reset or a flush, the first instruction has `out_start` = 0. Each later instruction starts at the previous `out_start` plus the previous `out_len`.
- R11: While `out_valid` = 1 and `out_ready` = 0, the output holds its value and its fields do not change.
- R12: `flush` = 1 clears `out_valid` on the next cycle and discards every byte held in the queue, including a partly collected instruction.
- R13: `in_ready` drops once the queue holds DEPTH bytes. With the output stalled and a stream of plain instructions, exactly DEPTH + 4 bytes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous discard of all buffered state |
| in_valid | input | 1 | Fetch byte valid |
| in_data | input | 8 | Fetch byte, big-endian instruction order |
| in_ready | output | 1 | Byte queue can accept a byte |
| out_valid | output | 1 | Classified instruction available |
| out_ready | input | 1 | Consumer accepts the instruction |
| out_fmt | output | 3 | 0 compressed, 1 plain, 2 48-bit, 3 64-bit, 4 block |
| out_len | output | 8 | Instruction length in bytes |
| out_start | output | OFF_W | Stream offset of the first byte |
| out_prefix | output | 16 | The two leading bytes |
| out_illegal | output | 1 | Block with a size below two halfwords |

## Verification
The same list of prefixes is sent under three output conditions: free flow, alternating backpressure, and a full stall. This tells apart mistakes in classification from mistakes in handshake timing. The list holds both 64-bit selector values, both block selectors, the two illegal block sizes, the largest block size, and a prefix from each of the other formats. Each of these lands on a different length, so any wrong boundary shifts every later prefix and offset. A partly delivered instruction separates correct stalling from early emission. A flush in the middle of an instruction, followed by a compressed instruction at offset zero, shows that the discarded bytes are really gone.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [2:0] {
    FMT_C16 = 3'd0,
    FMT_W32 = 3'd1,
    FMT_P48 = 3'd2,
    FMT_P64 = 3'd3,
    FMT_BLK = 3'd4
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [7:0] len;      // bytes
    logic       illegal;
  } cls_t;
endpackage

// File: rtl/vlp_classify.sv
module vlp_classify
  import vlp_pkg::*;
#(
  parameter logic [15:0] C16_MASK  = 16'hFE00,
  parameter logic [15:0] C16_MATCH = 16'h0000,
  parameter logic [15:0] P48_MASK  = 16'hFC00,
  parameter logic [15:0] P48_MATCH = 16'h0400
) (
  input  logic [15:0] prefix,
  output cls_t        cls
);
  localparam int MAJ_W = 6;
  localparam int SEL_W = 3;
  localparam int TAIL_W = 16 - MAJ_W - SEL_W;

  logic [MAJ_W-1:0]  major;
  logic [SEL_W-1:0]  sel;
  logic [TAIL_W-1:0] tail;

  assign major = prefix[15 -: MAJ_W];
  assign sel   = prefix[15-MAJ_W -: SEL_W];
  assign tail  = prefix[TAIL_W-1:0];

  always_comb begin
    cls.fmt     = FMT_W32;
    cls.len     = 8'd4;
    cls.illegal = 1'b0;
    if (major == '0 && sel[2:1] == 2'b10) begin
      cls.fmt = FMT_P64;
      cls.len = 8'd8;
    end else if (major == '0 && sel[2:1] == 2'b11) begin
      cls.fmt = FMT_BLK;
      if (tail < TAIL_W'(2)) begin
        cls.illegal = 1'b1;
        cls.len     = 8'd2;
      end else begin
        cls.len = 8'({tail, 1'b0});
      end
    end else if ((prefix & P48_MASK) == P48_MATCH) begin
      cls.fmt = FMT_P48;
      cls.len = 8'd6;
    end else if ((prefix & C16_MASK) == C16_MATCH) begin
      cls.fmt = FMT_C16;
      cls.len = 8'd2;
    end
  end
endmodule

// File: rtl/vlp_bytebuf.sv
module vlp_bytebuf #(
  parameter int DEPTH = 256,
  parameter int LEN_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             pop_en,
  input  logic [LEN_W-1:0] pop_len,
  output logic [7:0]       head0,
  output logic [7:0]       head1,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW-1:0] rp_next1;

  initial begin
    if ((1 << AW) != DEPTH) $error("DEPTH must be a power of two");
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign rp_next1 = rp + AW'(1);
  assign head0    = mem[rp];
  assign head1    = mem[rp_next1];

  always_ff @(posedge clk) begin
    if (wr_en && !full && !flush) mem[wp] <= wr_data;
  end

  logic             push;
  logic [CNT_W-1:0] pop_amt;
  assign push    = wr_en && !full && !flush;
  assign pop_amt = pop_en ? CNT_W'(pop_len) : '0;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop_en) rp <= rp + AW'(pop_len);
      count <= count + CNT_W'(push) - pop_amt;
    end
  end

  // R9: never remove bytes that are not present
  a_r9_no_underpop: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> (CNT_W'(pop_len) <= count));
  // R13: occupancy bounded by DEPTH
  a_r13_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/vlp_predecode.sv
module vlp_predecode
  import vlp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFF_W = 16,
  parameter logic [15:0] C16_MASK  = 16'hFE00,
  parameter logic [15:0] C16_MATCH = 16'h0000,
  parameter logic [15:0] P48_MASK  = 16'hFC00,
  parameter logic [15:0] P48_MATCH = 16'h0400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_fmt,
  output logic [7:0]       out_len,
  output logic [OFF_W-1:0] out_start,
  output logic [15:0]      out_prefix,
  output logic             out_illegal
);
  localparam int LEN_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  initial begin
    if (DEPTH < 254) $error("DEPTH must hold the largest block (254 bytes)");
  end

  logic [7:0]       h0, h1;
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             load;
  logic [OFF_W-1:0] next_off;
  cls_t             cls;

  vlp_bytebuf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .pop_en  (load),
    .pop_len (cls.len),
    .head0   (h0),
    .head1   (h1),
    .count   (cnt),
    .full    (full)
  );

  vlp_classify #(
    .C16_MASK(C16_MASK), .C16_MATCH(C16_MATCH),
    .P48_MASK(P48_MASK), .P48_MATCH(P48_MATCH)
  ) u_cls (
    .prefix ({h0, h1}),
    .cls    (cls)
  );

  assign in_ready = !full;
  assign load = !flush && (cnt >= CNT_W'(2)) && (cnt >= CNT_W'(cls.len))
                && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid   <= 1'b0;
      next_off    <= '0;
      out_fmt     <= '0;
      out_len     <= '0;
      out_start   <= '0;
      out_prefix  <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_fmt     <= cls.fmt;
      out_len     <= cls.len;
      out_start   <= next_off;
      out_prefix  <= {h0, h1};
      out_illegal <= cls.illegal;
      next_off    <= next_off + OFF_W'(cls.len);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: stalled output holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=>
      out_valid && $stable(out_start) && $stable(out_prefix) && $stable(out_len));
  // R12: flush empties the output stage
  a_r12_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);
  // R5: illegal only on short blocks, two bytes
  a_r5_illegal_len: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_fmt == FMT_BLK && out_len == 8'd2);
  // R3: 64-bit format always eight bytes
  a_r3_len64: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_fmt == FMT_P64 |-> out_len == 8'd8);
endmodule

// File: tb/tb_vlp_predecode.sv
module tb_vlp_predecode;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_fmt;
  logic [7:0]  out_len;
  logic [15:0] out_start;
  logic [15:0] out_prefix;
  logic        out_illegal;

  vlp_predecode #(.DEPTH(DEPTH), .OFF_W(16)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_fmt(out_fmt), .out_len(out_len), .out_start(out_start),
    .out_prefix(out_prefix), .out_illegal(out_illegal)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [2:0]  fmt;
    logic [7:0]  len;
    logic [15:0] start;
    logic [15:0] prefix;
    logic        ill;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  int          bp_mode = 0;  // 0 free, 1 alternate, 2 stalled
  int          cyc = 0;
  logic [15:0] exp_off = '0;
  logic [7:0]  fill = 8'h11;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [2:0] f, input logic ill);
    case (f)
      3'd0: return "R7";
      3'd1: return "R8";
      3'd2: return "R6";
      3'd3: return "R3";
      default: return ill ? "R5" : "R4";
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      default: out_ready = 1'b0;
    endcase
    if (!rst && !flush && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected output", out_prefix, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_fmt == e.fmt && out_len == e.len && out_illegal == e.ill,
              tag_of(e.fmt, e.ill), "fmt/len/illegal",
              {out_fmt, out_len, 3'b0, out_illegal}, {e.fmt, e.len, 3'b0, e.ill});
        check(out_prefix == e.prefix, "R2", "prefix", out_prefix, e.prefix);
        check(out_start == e.start, "R10", "start", out_start, e.start);
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_instr(input logic [15:0] p, input logic [7:0] len,
                              input logic [2:0] fmt, input logic ill);
    exp_t e;
    e.fmt = fmt; e.len = len; e.start = exp_off; e.prefix = p; e.ill = ill;
    sb.push_back(e);
    exp_off = exp_off + 16'(len);
  endtask

  task automatic send_instr(input logic [15:0] p, input logic [7:0] len,
                            input logic [2:0] fmt, input logic ill);
    expect_instr(p, len, fmt, ill);
    push_byte(p[15:8]);
    push_byte(p[7:0]);
    for (int i = 2; i < int'(len); i++) begin
      push_byte(fill);
      fill = fill + 8'd7;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R10", "pending items drained", sb.size(), 0);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    sb.delete();
    exp_off = '0;
  endtask

  task automatic send_list();
    send_instr(16'h0123, 8'd2,   3'd0, 1'b0);  // R7
    send_instr(16'h7C08, 8'd4,   3'd1, 1'b0);  // R8
    send_instr(16'h05AB, 8'd6,   3'd2, 1'b0);  // R6
    send_instr(16'h0200, 8'd8,   3'd3, 1'b0);  // R3 selector 100
    send_instr(16'h0280, 8'd8,   3'd3, 1'b0);  // R3 selector 101
    send_instr(16'h0305, 8'd10,  3'd4, 1'b0);  // R4 selector 110
    send_instr(16'h0383, 8'd6,   3'd4, 1'b0);  // R4 selector 111
    send_instr(16'h0301, 8'd2,   3'd4, 1'b1);  // R5 size 1
    send_instr(16'h0380, 8'd2,   3'd4, 1'b1);  // R5 size 0
    send_instr(16'hFFFF, 8'd4,   3'd1, 1'b0);  // R8
    send_instr(16'h037F, 8'd254, 3'd4, 1'b0);  // R4 largest block
    send_instr(16'h0800, 8'd4,   3'd1, 1'b0);  // R8
    send_instr(16'h0002, 8'd2,   3'd0, 1'b0);  // R7
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // free flow, then alternating backpressure
    bp_mode = 0;
    send_list();
    drain();
    bp_mode = 1;
    send_list();
    drain();

    // R9: partial instruction stalls
    bp_mode = 0;
    expect_instr(16'h7C08, 8'd4, 3'd1, 1'b0);
    push_byte(8'h7C);
    push_byte(8'h08);
    push_byte(8'hAA);
    repeat (8) @(negedge clk);
    check(out_valid == 1'b0, "R9", "no output before last byte", out_valid, 0);
    push_byte(8'hBB);
    send_instr(16'h0123, 8'd2, 3'd0, 1'b0);
    drain();

    // R11: hold under stall
    bp_mode = 2;
    send_instr(16'h05AB, 8'd6, 3'd2, 1'b0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b1, "R11", "valid while stalled", out_valid, 1);
    begin
      logic [15:0] s0, p0;
      s0 = out_start;
      p0 = out_prefix;
      repeat (6) @(negedge clk);
      check(out_valid == 1'b1 && out_start == s0 && out_prefix == p0, "R11",
            "fields held", {out_start, out_prefix}, {s0, p0});
    end
    bp_mode = 0;
    drain();

    // R12: flush discards output and partial bytes
    bp_mode = 2;
    send_instr(16'h7C08, 8'd4, 3'd1, 1'b0);
    push_byte(8'h02);
    push_byte(8'h00);
    push_byte(8'h55);
    check(out_valid == 1'b1, "R12", "valid before flush", out_valid, 1);
    do_flush();
    check(out_valid == 1'b0, "R12", "valid after flush", out_valid, 0);
    bp_mode = 0;
    send_instr(16'h0123, 8'd2, 3'd0, 1'b0);  // starts at 0
    send_instr(16'h7C08, 8'd4, 3'd1, 1'b0);
    drain();

    // R13: fill the queue
    bp_mode = 2;
    begin
      int acc;
      acc = 0;
      for (int i = 0; i < 400; i++) begin
        in_valid = 1'b1;
        in_data  = (acc % 4 == 0) ? 8'h08 : 8'h00;
        if (in_ready) acc++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      check(acc == DEPTH + 4, "R13", "bytes accepted when stalled", acc, DEPTH + 4);
      check(in_ready == 1'b0, "R13", "in_ready when full", in_ready, 0);
    end
    do_flush();
    check(in_ready == 1'b1, "R12", "queue empty after flush", in_ready, 1);
    bp_mode = 0;
    send_instr(16'h0200, 8'd8, 3'd3, 1'b0);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule